// File: doc/BRIEF.md
# Dual-Bank Precharge Timing Tracker

This block sits on the controller side of a two-bank synchronous DRAM interface and follows, cycle by cycle, the state of each bank. It receives already decoded commands (activate, read, write, precharge) with a bank select and the auto-precharge address bit. For each bank it times how long the bank has been open, how long an internal auto-precharge must wait, and how long precharge recovery takes. It accepts a command only when the target bank can legally take it, and it flags a rejected command with a single-cycle error pulse.

The command generator uses the outputs to decide what it may issue next. Each bank reports whether it is open and whether it can take a new command. A shared flag shows that every bank is idle, which is the condition for refresh, power-down and mode programming. Each bank also has a flag that rises when the bank has stayed open past the maximum allowed time. A precharge with the auto-precharge bit high acts on all banks. It is accepted only when every open bank has met the minimum active time.

Top module: `bank_prech_tracker`

## Requirements
- R1: After reset every bank is idle and ready, `all_idle` is 1, and `ras_viol` and `cmd_err` are 0.
- R2: Command codes on `cmd_op` are 0 no-op, 1 activate, 2 read, 3 write, 4 precharge. An activate to an idle bank makes `bank_open` of that bank 1 from the next cycle. An activate to any bank that is not idle raises `cmd_err` in that cycle and changes nothing.
- R3: Take an activate in cycle a and a precharge (`cmd_ap`=0) to the same open bank in cycle a+k. The precharge is accepted when k >= T_RAS_MIN. Otherwise it raises `cmd_err` and the bank stays open.
- R4: After a precharge is accepted, or an internal precharge starts, in cycle p, the bank is neither open nor ready in cycles p+1 to p+T_RP-1. It is idle and ready from cycle p+T_RP.
- R5: `ras_viol` of a bank is 1 exactly in the cycles where the bank is open and more than T_RAS_MAX cycles have passed since its activate (default level mode).
- R6: A read or write with `cmd_ap`=0 to an open bank is accepted without error, and the bank stays open and ready. A read or write to a bank that is not open raises `cmd_err`.
- R7: A write with `cmd_ap`=1 in cycle n starts the internal precharge in cycle max(n+BURST_LEN, a+T_RAS_MIN). A read with `cmd_ap`=1 starts it in cycle max(n+CAS_LAT+BURST_LEN-1, a+T_RAS_MIN). Here a is the activate cycle. The bank stays open until that cycle and then follows R4.
- R8: From an accepted auto-precharge request until the bank is idle, `bank_ready` of that bank is 0. Every activate, read, write or precharge to that bank raises `cmd_err`.
- R9: A precharge with `cmd_ap`=1 (all banks) is accepted only if every bank is either idle or open for at least T_RAS_MIN cycles. All open banks then start precharge in that cycle. Otherwise `cmd_err` is raised and no bank changes.
- R10: `all_idle` is 1 exactly when every bank is idle: not open, not locked and not recovering.
- R11: A single-bank precharge to an idle bank, and command codes 0, 5, 6 and 7, raise no error and change no bank state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_op | input | 3 | Decoded command code |
| cmd_ap | input | 1 | Auto-precharge / all-banks address bit |
| cmd_bank | input | SEL_W | Target bank |
| bank_open | output | NUM_BANKS | Bank is open (including pending auto-precharge) |
| bank_ready | output | NUM_BANKS | Bank accepts new commands |
| ras_viol | output | NUM_BANKS | Bank open longer than T_RAS_MAX |
| all_idle | output | 1 | Every bank idle |
| cmd_err | output | 1 | Current command rejected |

## Verification
Several events can land in the same cycle. The one that matters most is a bank's internal auto-precharge starting while an explicit command targets the other bank. Another is a precharge-all arriving in the very cycle the later-opened bank first meets its minimum active time. The bench provokes both by issuing back-to-back commands every cycle across these moments, and then adds a long stretch of random commands. A behavioural model judges every cycle. It tracks each bank by absolute cycle numbers: the activate cycle and the scheduled precharge cycle. It compares open, ready, violation, all-idle and error against the design.

// File: rtl/bpt_pkg.sv
`timescale 1ns/1ps
package bpt_pkg;

   typedef enum logic [1:0] {
      BS_IDLE   = 2'd0,
      BS_OPEN   = 2'd1,
      BS_APWAIT = 2'd2,
      BS_PRECH  = 2'd3
   } bank_st_t;

   localparam logic [2:0] OP_NOP = 3'd0;
   localparam logic [2:0] OP_ACT = 3'd1;
   localparam logic [2:0] OP_RD  = 3'd2;
   localparam logic [2:0] OP_WR  = 3'd3;
   localparam logic [2:0] OP_PRE = 3'd4;

endpackage

// File: rtl/bpt_bank.sv
`timescale 1ns/1ps
module bpt_bank
   import bpt_pkg::*;
#(
   parameter int T_RAS_MIN  = 5,
   parameter int T_RAS_MAX  = 40,
   parameter int T_RP       = 3,
   parameter int RD_DLY     = 6,
   parameter int WR_DLY     = 4,
   parameter bit VIOL_LATCH = 1'b0
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     go_act,
   input  logic     go_ap_rd,
   input  logic     go_ap_wr,
   input  logic     go_pre,
   output bank_st_t st,
   output logic     ras_ok,
   output logic     viol
);

   localparam int AGE_SAT = T_RAS_MAX + 1;
   localparam int AGE_W   = $clog2(AGE_SAT + 1);
   localparam int RP_W    = $clog2(T_RP);
   localparam int DLY_MAX = (RD_DLY > WR_DLY) ? RD_DLY : WR_DLY;
   localparam int DLY_W   = $clog2(DLY_MAX + 1);

   bank_st_t          st_q;
   logic [AGE_W-1:0]  age_q;
   logic [RP_W-1:0]   rp_q;
   logic [DLY_W-1:0]  dly_q;
   logic              open_now;
   logic              age_min;
   logic              age_over;
   logic [AGE_W-1:0]  age_inc;

   assign open_now = (st_q == BS_OPEN) || (st_q == BS_APWAIT);
   assign age_min  = age_q >= AGE_W'(T_RAS_MIN);
   assign age_over = age_q == AGE_W'(AGE_SAT);
   assign age_inc  = age_over ? age_q : age_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= BS_IDLE;
         age_q <= '0;
         rp_q  <= '0;
         dly_q <= '0;
      end else begin
         case (st_q)
            BS_IDLE: begin
               if (go_act) begin
                  st_q  <= BS_OPEN;
                  age_q <= AGE_W'(1);
               end
            end
            BS_OPEN: begin
               age_q <= age_inc;
               if (go_pre) begin
                  st_q <= BS_PRECH;
                  rp_q <= RP_W'(T_RP - 1);
               end else if (go_ap_rd) begin
                  st_q  <= BS_APWAIT;
                  dly_q <= DLY_W'(RD_DLY - 1);
               end else if (go_ap_wr) begin
                  st_q  <= BS_APWAIT;
                  dly_q <= DLY_W'(WR_DLY - 1);
               end
            end
            BS_APWAIT: begin
               age_q <= age_inc;
               if (dly_q == '0 && age_min) begin
                  st_q <= BS_PRECH;
                  rp_q <= RP_W'(T_RP - 1);
               end else if (dly_q != '0) begin
                  dly_q <= dly_q - 1'b1;
               end
            end
            default: begin
               if (rp_q == RP_W'(1)) st_q <= BS_IDLE;
               else                  rp_q <= rp_q - 1'b1;
            end
         endcase
      end
   end

   assign st     = st_q;
   assign ras_ok = (st_q == BS_OPEN) && age_min;

   generate
      if (VIOL_LATCH) begin : g_viol_hold
         logic hold_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                hold_q <= 1'b0;
            else if (st_q == BS_IDLE)  hold_q <= 1'b0;
            else if (open_now && age_over) hold_q <= 1'b1;
         end
         assign viol = hold_q | (open_now & age_over);
      end else begin : g_viol_level
         assign viol = open_now & age_over;
         // R5: a level flag is never shown by a closed bank
         a_r5_viol_only_open: assert property (@(posedge clk) disable iff (!rst_n)
            viol |-> (st_q == BS_OPEN || st_q == BS_APWAIT));
      end
   endgenerate

   a_r2_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
      go_act |=> (st_q == BS_OPEN));

   a_r3_pre_after_min: assert property (@(posedge clk) disable iff (!rst_n)
      go_pre |-> (age_q >= AGE_W'(T_RAS_MIN)));

   a_r4_no_cmd_in_recovery: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == BS_PRECH) |-> !(go_act || go_pre || go_ap_rd || go_ap_wr));

   a_r7_ap_respects_min: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == BS_APWAIT) |=> ((st_q != BS_PRECH) || ($past(age_q) >= AGE_W'(T_RAS_MIN))));

endmodule

// File: rtl/bpt_accept.sv
`timescale 1ns/1ps
module bpt_accept
   import bpt_pkg::*;
#(
   parameter int NUM_BANKS = 2,
   parameter int SEL_W     = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [2:0]           op,
   input  logic                 ap_bit,
   input  logic [SEL_W-1:0]     sel,
   input  bank_st_t             st [NUM_BANKS],
   input  logic [NUM_BANKS-1:0] ras_ok,
   output logic [NUM_BANKS-1:0] go_act,
   output logic [NUM_BANKS-1:0] go_ap_rd,
   output logic [NUM_BANKS-1:0] go_ap_wr,
   output logic [NUM_BANKS-1:0] go_pre,
   output logic                 cmd_err
);

   bank_st_t tgt;
   logic     all_ok;

   assign tgt = st[sel];

   always_comb begin
      all_ok = 1'b1;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (!(st[b] == BS_IDLE || ras_ok[b])) all_ok = 1'b0;
      end
   end

   always_comb begin
      go_act   = '0;
      go_ap_rd = '0;
      go_ap_wr = '0;
      go_pre   = '0;
      cmd_err  = 1'b0;
      case (op)
         OP_ACT: begin
            if (tgt == BS_IDLE) go_act[sel] = 1'b1;
            else                cmd_err     = 1'b1;
         end
         OP_RD: begin
            if (tgt == BS_OPEN) go_ap_rd[sel] = ap_bit;
            else                cmd_err       = 1'b1;
         end
         OP_WR: begin
            if (tgt == BS_OPEN) go_ap_wr[sel] = ap_bit;
            else                cmd_err       = 1'b1;
         end
         OP_PRE: begin
            if (ap_bit) begin
               if (all_ok) begin
                  for (int b = 0; b < NUM_BANKS; b++) go_pre[b] = (st[b] == BS_OPEN);
               end else begin
                  cmd_err = 1'b1;
               end
            end else if (tgt != BS_IDLE) begin
               if (ras_ok[sel]) go_pre[sel] = 1'b1;
               else             cmd_err     = 1'b1;
            end
         end
         default: ;
      endcase
   end

   a_r8_locked_rejects: assert property (@(posedge clk) disable iff (!rst_n)
      ((op >= OP_ACT) && (op <= OP_PRE) && (tgt == BS_APWAIT || tgt == BS_PRECH))
      |-> cmd_err);

   a_r11_no_err_on_spare: assert property (@(posedge clk) disable iff (!rst_n)
      (op > OP_PRE || op == OP_NOP) |-> !cmd_err);

   generate
      for (genvar g = 0; g < NUM_BANKS; g++) begin : g_chk
         a_r9_all_needs_min: assert property (@(posedge clk) disable iff (!rst_n)
            (op == OP_PRE && ap_bit && !cmd_err) |-> (st[g] == BS_IDLE || ras_ok[g]));
      end
   endgenerate

endmodule

// File: rtl/bank_prech_tracker.sv
`timescale 1ns/1ps
module bank_prech_tracker
   import bpt_pkg::*;
#(
   parameter int NUM_BANKS  = 2,
   parameter int T_RAS_MIN  = 5,
   parameter int T_RAS_MAX  = 40,
   parameter int T_RP       = 3,
   parameter int BURST_LEN  = 4,
   parameter int CAS_LAT    = 3,
   parameter bit VIOL_LATCH = 1'b0,
   localparam int SEL_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [2:0]           cmd_op,
   input  logic                 cmd_ap,
   input  logic [SEL_W-1:0]     cmd_bank,
   output logic [NUM_BANKS-1:0] bank_open,
   output logic [NUM_BANKS-1:0] bank_ready,
   output logic [NUM_BANKS-1:0] ras_viol,
   output logic                 all_idle,
   output logic                 cmd_err
);

   localparam int RD_DLY = CAS_LAT + BURST_LEN - 1;
   localparam int WR_DLY = BURST_LEN;

   generate
      if (NUM_BANKS < 2 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_nb
         $error("NUM_BANKS must be a power of two and at least 2");
      end
      if (T_RAS_MIN < 1 || T_RAS_MIN > T_RAS_MAX) begin : g_bad_ras
         $error("need 1 <= T_RAS_MIN <= T_RAS_MAX");
      end
      if (T_RP < 2) begin : g_bad_rp
         $error("T_RP must be at least 2");
      end
      if (BURST_LEN < 1 || CAS_LAT < 1) begin : g_bad_burst
         $error("BURST_LEN and CAS_LAT must be at least 1");
      end
   endgenerate

   bank_st_t             st_arr [NUM_BANKS];
   logic [NUM_BANKS-1:0] ras_ok;
   logic [NUM_BANKS-1:0] go_act, go_ap_rd, go_ap_wr, go_pre;

   bpt_accept #(
      .NUM_BANKS (NUM_BANKS),
      .SEL_W     (SEL_W)
   ) accept_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .op       (cmd_op),
      .ap_bit   (cmd_ap),
      .sel      (cmd_bank),
      .st       (st_arr),
      .ras_ok   (ras_ok),
      .go_act   (go_act),
      .go_ap_rd (go_ap_rd),
      .go_ap_wr (go_ap_wr),
      .go_pre   (go_pre),
      .cmd_err  (cmd_err)
   );

   generate
      for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
         bpt_bank #(
            .T_RAS_MIN  (T_RAS_MIN),
            .T_RAS_MAX  (T_RAS_MAX),
            .T_RP       (T_RP),
            .RD_DLY     (RD_DLY),
            .WR_DLY     (WR_DLY),
            .VIOL_LATCH (VIOL_LATCH)
         ) bank_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .go_act   (go_act[g]),
            .go_ap_rd (go_ap_rd[g]),
            .go_ap_wr (go_ap_wr[g]),
            .go_pre   (go_pre[g]),
            .st       (st_arr[g]),
            .ras_ok   (ras_ok[g]),
            .viol     (ras_viol[g])
         );

         assign bank_open[g]  = (st_arr[g] == BS_OPEN) || (st_arr[g] == BS_APWAIT);
         assign bank_ready[g] = (st_arr[g] == BS_OPEN) || (st_arr[g] == BS_IDLE);

         a_r6_rw_keeps_open: assert property (@(posedge clk) disable iff (!rst_n)
            ((cmd_op == OP_RD || cmd_op == OP_WR) && !cmd_ap && cmd_bank == SEL_W'(g)
             && !cmd_err) |=> (bank_open[g] && bank_ready[g]));
      end
   endgenerate

   always_comb begin
      all_idle = 1'b1;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (st_arr[b] != BS_IDLE) all_idle = 1'b0;
      end
   end

   a_r10_idle_consistent: assert property (@(posedge clk) disable iff (!rst_n)
      all_idle |-> (bank_open == '0 && bank_ready == '1 && ras_viol == '0));

   a_r1_after_reset: assert property (@(posedge clk)
      $rose(rst_n) |-> (all_idle && !cmd_err && bank_open == '0));

endmodule

// File: tb/bank_prech_tracker_tb.sv
`timescale 1ns/1ps
module bank_prech_tracker_tb_top;

   localparam int NB    = 2;
   localparam int TMIN  = 5;
   localparam int TMAX  = 40;
   localparam int TRP   = 3;
   localparam int BL    = 4;
   localparam int CL    = 3;
   localparam int D_RD  = CL + BL - 1;
   localparam int D_WR  = BL;

   localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2,
                          C_WR = 3'd3, C_PRE = 3'd4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2:0]    op_r = 3'd0;
   logic          ap_r = 1'b0;
   logic [0:0]    bank_r = 1'b0;
   logic [NB-1:0] bank_open, bank_ready, ras_viol;
   logic          all_idle, cmd_err;

   int    n_cmp = 0;
   int    n_bad = 0;
   int    cyc = 0;
   string tag = "R1";
   bit    done = 1'b0;

   int mode  [NB];
   int act_c [NB];
   int pc    [NB];

   always #4 clk = ~clk;

   bank_prech_tracker #(
      .NUM_BANKS (NB), .T_RAS_MIN (TMIN), .T_RAS_MAX (TMAX), .T_RP (TRP),
      .BURST_LEN (BL), .CAS_LAT (CL), .VIOL_LATCH (1'b0)
   ) dut_i (
      .clk (clk), .rst_n (rst_n), .cmd_op (op_r), .cmd_ap (ap_r),
      .cmd_bank (bank_r), .bank_open (bank_open), .bank_ready (bank_ready),
      .ras_viol (ras_viol), .all_idle (all_idle), .cmd_err (cmd_err)
   );

   task automatic check(input string fld, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s cycle %0d: actual %h expected %h", tag, fld, cyc, act, exp);
      end
   endtask

   // reference model, evaluated mid-cycle
   always @(negedge clk) begin
      if (!rst_n) begin
         for (int b = 0; b < NB; b++) begin
            mode[b] = 0; act_c[b] = 0; pc[b] = 0;
         end
         cyc = 0;
      end else begin
         logic [7:0] e_open, e_rdy, e_viol;
         logic       e_idle, e_err, all_ok;
         int         s;
         e_open = '0; e_rdy = '0; e_viol = '0; e_idle = 1'b1; e_err = 1'b0;
         for (int b = 0; b < NB; b++) begin
            if (mode[b] == 2 && cyc >= pc[b] + TRP) mode[b] = 0;
            e_open[b] = (mode[b] == 1) || (mode[b] == 2 && cyc <= pc[b]);
            e_rdy[b]  = (mode[b] == 0) || (mode[b] == 1);
            e_viol[b] = e_open[b] && (cyc - act_c[b]) > TMAX;
            if (mode[b] != 0) e_idle = 1'b0;
         end
         s = int'(bank_r);
         all_ok = 1'b1;
         for (int b = 0; b < NB; b++)
            if (!(mode[b] == 0 || (mode[b] == 1 && cyc - act_c[b] >= TMIN))) all_ok = 1'b0;
         case (op_r)
            C_ACT: if (mode[s] != 0) e_err = 1'b1;
                   else begin mode[s] = 1; act_c[s] = cyc; end
            C_RD, C_WR: begin
               if (mode[s] != 1) e_err = 1'b1;
               else if (ap_r) begin
                  int d;
                  d = (op_r == C_RD) ? D_RD : D_WR;
                  mode[s] = 2;
                  pc[s] = (cyc + d > act_c[s] + TMIN) ? cyc + d : act_c[s] + TMIN;
               end
            end
            C_PRE: begin
               if (ap_r) begin
                  if (!all_ok) e_err = 1'b1;
                  else for (int b = 0; b < NB; b++)
                     if (mode[b] == 1) begin mode[b] = 2; pc[b] = cyc; end
               end else if (mode[s] != 0) begin
                  if (mode[s] == 1 && cyc - act_c[s] >= TMIN) begin
                     mode[s] = 2; pc[s] = cyc;
                  end else e_err = 1'b1;
               end
            end
            default: ;
         endcase
         check("bank_open",  8'(bank_open),  e_open);
         check("bank_ready", 8'(bank_ready), e_rdy);
         check("ras_viol",   8'(ras_viol),   e_viol);
         check("all_idle",   8'(all_idle),   8'(e_idle));
         check("cmd_err",    8'(cmd_err),    8'(e_err));
         cyc++;
      end
   end

   task automatic cmd(input logic [2:0] o, input int b, input logic a);
      @(posedge clk); #1;
      op_r = o; bank_r = 1'(b); ap_r = a;
   endtask

   task automatic nop(input int n);
      for (int i = 0; i < n; i++) cmd(C_NOP, 0, 1'b0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      tag = "R1";  nop(3);
      // R2: open, then reopen attempt is rejected
      tag = "R2";  cmd(C_ACT, 0, 0); cmd(C_ACT, 0, 0); nop(2);
      // R3: precharge every cycle, rejected until age reaches TMIN
      tag = "R3";  cmd(C_ACT, 1, 0);
      for (int i = 0; i < TMIN + 1; i++) cmd(C_PRE, 1, 0);
      // R4: activate every cycle across the recovery window
      tag = "R4";  for (int i = 0; i < TRP + 2; i++) cmd(C_ACT, 1, 0);
      // R6: read/write without auto-precharge keep the bank open
      tag = "R6";  cmd(C_RD, 0, 0); cmd(C_WR, 0, 0); cmd(C_WR, 1, 0);
      // R5: keep both banks open past the maximum
      tag = "R5";  nop(TMAX); cmd(C_PRE, 0, 0); nop(2);
      tag = "R9";  cmd(C_PRE, 0, 1); nop(TRP + 1);
      // R11: harmless commands
      tag = "R11"; cmd(C_PRE, 0, 0); cmd(3'd5, 1, 1); cmd(3'd6, 0, 0); cmd(3'd7, 1, 0);
      tag = "R6";  cmd(C_RD, 0, 0); cmd(C_WR, 1, 1);
      // R7: write auto-precharge bounded by minimum active time
      tag = "R7";  cmd(C_ACT, 0, 0); cmd(C_WR, 0, 1);
      tag = "R8";  for (int i = 0; i < TMIN + TRP + 2; i++) cmd(C_RD, 0, 0);
      // R7: read auto-precharge bounded by burst, other bank driven meanwhile
      tag = "R7";  cmd(C_ACT, 1, 0); cmd(C_ACT, 0, 0); nop(10); cmd(C_RD, 1, 1);
      for (int i = 0; i < D_RD + TRP + 1; i++) cmd((i % 2 == 0) ? C_ACT : C_WR, i % 2, 0);
      tag = "R9";  cmd(C_PRE, 0, 1); nop(TRP + 1);
      // R9: precharge-all every cycle until the later bank meets TMIN
      cmd(C_ACT, 0, 0); cmd(C_ACT, 1, 0);
      for (int i = 0; i < TMIN + 2; i++) cmd(C_PRE, 1, 1);
      nop(TRP);
      // R9: precharge-all while one bank is locked by auto-precharge
      cmd(C_ACT, 0, 0); cmd(C_ACT, 1, 0); nop(TMIN); cmd(C_WR, 0, 1);
      for (int i = 0; i < D_WR + TRP + 2; i++) cmd(C_PRE, 0, 1);
      nop(TRP + 2);
      // R10: mixed random traffic
      tag = "R10";
      for (int i = 0; i < 1500; i++) begin
         int r;
         r = $urandom_range(9, 0);
         cmd((r > 7) ? C_NOP : 3'(r), $urandom_range(1, 0), 1'($urandom_range(3, 0) == 0));
      end
      nop(TMAX + 5);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule